// File: doc/BRIEF.md
# Read-After-Write Interlock for a Five-Stage In-Order Pipeline

This block decides, every cycle, whether the instruction in the decode stage has to wait. It looks at the instruction's two source register indices and checks each one against the destinations of the instructions already past decode. A later stage only counts if it holds a valid instruction that writes a register. The five stages are fetch, decode, execute, memory access and write-back, and the register file is written only in write-back. The block keeps its own copy of the destination index, write flag and valid flag for each of those later stages. That copy advances every cycle, whether or not the pipeline is stalled.

When a source the decoding instruction really reads will be written by an in-flight instruction, the block raises a stall. A stall holds the program counter and the fetch/decode register, and it feeds an empty slot (a bubble) into execute in place of the held instruction. The stall clears by itself once the writer has moved out of the stages being compared.

Only true read-after-write cases stall. A decoding instruction that writes the same register as an older one, or that writes a register an older one read, goes ahead without waiting.

A parameter sets whether the write-back stage takes part in the comparison. By default the register file writes in the first half of the cycle and reads in the second half, so a writer in write-back needs no stall and that stage is left out.

Top module: `rawdep_guard`

## Requirements
- R1: After reset no later stage holds a valid instruction: `stall_o` is 0 and `ex_valid`/`ex_wr` are 0.
- R2: When the execute stage holds a valid writer whose non-zero destination equals source A, and source A is in use, `stall_o` is 1.
- R3: The same match through source B (with its use flag set) also raises `stall_o`.
- R4: A matching valid writer in the memory stage raises `stall_o`. A reader issued one instruction after its writer stalls for exactly 1 cycle.
- R5: With the default write-first register file (`RF_WRITE_FIRST`=1), a matching writer in write-back does not stall. A reader issued right after its writer stalls for exactly 2 cycles.
- R6: A source whose use flag is 0 never causes a stall, whatever its index.
- R7: A later stage whose instruction is invalid or has its write flag at 0 never causes a stall.
- R8: A destination of register 0 never matches, so it never stalls a reader of register 0.
- R9: No stall for write-after-write (same destination as an in-flight writer) or write-after-read (writing a register that an older instruction read).
- R10: While `stall_o` is 1, `hold_pc` and `hold_ifid` are 1. On the next cycle execute holds a bubble: `ex_valid`=0 and `ex_wr`=0.
- R11: The stage copy advances every cycle, so a stall ends without any outside action once the writer has left the compared stages.
- R12: When there is no stall, the decode instruction's valid flag, write flag and destination appear on `ex_valid`, `ex_wr` and `ex_dst` after one clock edge.
- R13: When `dec_valid` is 0, `stall_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_src_a | input | RF_AW | First source register index |
| dec_rd_a | input | 1 | First source is read |
| dec_src_b | input | RF_AW | Second source register index |
| dec_rd_b | input | 1 | Second source is read |
| dec_dst | input | RF_AW | Destination index of the decoding instruction |
| dec_wr | input | 1 | Decoding instruction writes a register |
| stall_o | output | 1 | Read-after-write hazard, decode must wait |
| hold_pc | output | 1 | Keep the program counter unchanged |
| hold_ifid | output | 1 | Keep the fetch/decode register unchanged |
| ex_bubble | output | 1 | Execute is loaded with an empty slot this edge |
| ex_valid | output | 1 | Execute stage holds a valid instruction |
| ex_wr | output | 1 | Execute stage instruction writes a register |
| ex_dst | output | RF_AW | Execute stage destination index |

## Verification
Writer/reader pairs are placed zero, one and two slots apart, and the bench counts how many cycles the stall lasts. This separates an execute-stage match (two cycles), a memory-stage match (one cycle) and a write-back writer that needs no stall.

Further patterns each remove one condition of a true hazard while the register indices still match:
- a source whose use flag is clear;
- a writer with its write flag clear, or an empty slot;
- register 0 as the destination;
- a decode slot that is not valid.

Any stall in these cases points at a missing qualifier. Same-destination and reversed-order pairs check that write-after-write and write-after-read never stall.

// File: rtl/rawdep_pkg.sv
package rawdep_pkg;

    parameter int RF_AW = 5;

    typedef enum int {
        STG_EX  = 0,
        STG_MEM = 1,
        STG_WB  = 2
    } stage_idx_e;

    typedef struct packed {
        logic             valid;
        logic             wr;
        logic [RF_AW-1:0] dst;
    } stage_tag_t;

    function automatic stage_tag_t empty_tag();
        stage_tag_t t;
        t = '0;
        return t;
    endfunction

    // true when the stage will write a real register equal to src
    function automatic logic tag_writes(input stage_tag_t t, input logic [RF_AW-1:0] src);
        return t.valid && t.wr && (t.dst != '0) && (t.dst == src);
    endfunction

endpackage

// File: rtl/rawdep_pipe.sv
module rawdep_pipe
    import rawdep_pkg::*;
#(
    parameter int N = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  stage_tag_t           head_in,
    output stage_tag_t [N-1:0]   stg_q
);

    for (genvar i = 0; i < N; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stg_q[i] <= empty_tag();
                else     stg_q[i] <= head_in;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stg_q[i] <= empty_tag();
                else     stg_q[i] <= stg_q[i-1];
            end
        end
    end

endmodule

// File: rtl/rawdep_cmp.sv
module rawdep_cmp
    import rawdep_pkg::*;
#(
    parameter int N    = 3,
    parameter int NCMP = 2
) (
    input  stage_tag_t [N-1:0] stg,
    input  logic [RF_AW-1:0]   src,
    input  logic               use_en,
    output logic               hit
);

    logic [N-1:0] match;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        localparam logic EN = (i < NCMP);
        assign match[i] = tag_writes(stg[i], src) & EN;
    end

    assign hit = use_en & (|match);

endmodule

// File: rtl/rawdep_ctl.sv
module rawdep_ctl
    import rawdep_pkg::*;
(
    input  logic             dec_valid,
    input  logic             dec_wr,
    input  logic [RF_AW-1:0] dec_dst,
    input  logic             hit_a,
    input  logic             hit_b,
    output logic             stall,
    output logic             hold_pc,
    output logic             hold_ifid,
    output logic             bubble,
    output stage_tag_t       ex_head
);

    always_comb begin
        stall     = dec_valid & (hit_a | hit_b);
        hold_pc   = stall;
        hold_ifid = stall;
        bubble    = stall | ~dec_valid;
        if (bubble) begin
            ex_head = empty_tag();
        end else begin
            ex_head.valid = 1'b1;
            ex_head.wr    = dec_wr;
            ex_head.dst   = dec_dst;
        end
    end

endmodule

// File: rtl/rawdep_guard.sv
module rawdep_guard
    import rawdep_pkg::*;
#(
    parameter int AW             = RF_AW,
    parameter int NUM_LATE       = 3,
    parameter bit RF_WRITE_FIRST = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dec_valid,
    input  logic [AW-1:0] dec_src_a,
    input  logic          dec_rd_a,
    input  logic [AW-1:0] dec_src_b,
    input  logic          dec_rd_b,
    input  logic [AW-1:0] dec_dst,
    input  logic          dec_wr,
    output logic          stall_o,
    output logic          hold_pc,
    output logic          hold_ifid,
    output logic          ex_bubble,
    output logic          ex_valid,
    output logic          ex_wr,
    output logic [AW-1:0] ex_dst
);

    localparam int NCMP = RF_WRITE_FIRST ? NUM_LATE - 1 : NUM_LATE;

    stage_tag_t [NUM_LATE-1:0] stg;
    stage_tag_t                ex_head;
    logic                      hit_a;
    logic                      hit_b;

    rawdep_pipe #(.N(NUM_LATE)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .head_in (ex_head),
        .stg_q   (stg)
    );

    rawdep_cmp #(.N(NUM_LATE), .NCMP(NCMP)) u_cmp_a (
        .stg    (stg),
        .src    (dec_src_a),
        .use_en (dec_rd_a),
        .hit    (hit_a)
    );

    rawdep_cmp #(.N(NUM_LATE), .NCMP(NCMP)) u_cmp_b (
        .stg    (stg),
        .src    (dec_src_b),
        .use_en (dec_rd_b),
        .hit    (hit_b)
    );

    rawdep_ctl u_ctl (
        .dec_valid (dec_valid),
        .dec_wr    (dec_wr),
        .dec_dst   (dec_dst),
        .hit_a     (hit_a),
        .hit_b     (hit_b),
        .stall     (stall_o),
        .hold_pc   (hold_pc),
        .hold_ifid (hold_ifid),
        .bubble    (ex_bubble),
        .ex_head   (ex_head)
    );

    assign ex_valid = stg[STG_EX].valid;
    assign ex_wr    = stg[STG_EX].wr;
    assign ex_dst   = stg[STG_EX].dst;

endmodule

// File: rtl/rawdep_guard_chk.sv
module rawdep_guard_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          dec_valid,
    input logic [AW-1:0] dec_src_a,
    input logic          dec_rd_a,
    input logic [AW-1:0] dec_src_b,
    input logic          dec_rd_b,
    input logic [AW-1:0] dec_dst,
    input logic          dec_wr,
    input logic          stall_o,
    input logic          hold_pc,
    input logic          hold_ifid,
    input logic          ex_valid,
    input logic          ex_wr,
    input logic [AW-1:0] ex_dst
);

    AST_EX_HIT_A: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_rd_a && ex_valid && ex_wr && ex_dst != '0 && ex_dst == dec_src_a) |-> stall_o); // R2

    AST_EX_HIT_B: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_rd_b && ex_valid && ex_wr && ex_dst != '0 && ex_dst == dec_src_b) |-> stall_o); // R3

    AST_UNUSED_SRC: assert property (@(posedge clk) disable iff (rst)
        (!dec_rd_a && !dec_rd_b) |-> !stall_o); // R6

    AST_ZERO_SRC: assert property (@(posedge clk) disable iff (rst)
        ((!dec_rd_a || dec_src_a == '0) && (!dec_rd_b || dec_src_b == '0)) |-> !stall_o); // R8

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> (hold_pc && hold_ifid)); // R10

    AST_BUBBLE_AFTER: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> (!ex_valid && !ex_wr)); // R10

    AST_EX_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !stall_o) |=> (ex_valid && ex_wr == $past(dec_wr) && ex_dst == $past(dec_dst))); // R12

    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !stall_o); // R13

endmodule

bind rawdep_guard rawdep_guard_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dec_valid (dec_valid),
    .dec_src_a (dec_src_a),
    .dec_rd_a  (dec_rd_a),
    .dec_src_b (dec_src_b),
    .dec_rd_b  (dec_rd_b),
    .dec_dst   (dec_dst),
    .dec_wr    (dec_wr),
    .stall_o   (stall_o),
    .hold_pc   (hold_pc),
    .hold_ifid (hold_ifid),
    .ex_valid  (ex_valid),
    .ex_wr     (ex_wr),
    .ex_dst    (ex_dst)
);

// File: tb/rawdep_guard_tb.sv
module rawdep_guard_tb;

    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst;
    logic          dec_valid;
    logic [AW-1:0] dec_src_a;
    logic          dec_rd_a;
    logic [AW-1:0] dec_src_b;
    logic          dec_rd_b;
    logic [AW-1:0] dec_dst;
    logic          dec_wr;
    logic          stall_o;
    logic          hold_pc;
    logic          hold_ifid;
    logic          ex_bubble;
    logic          ex_valid;
    logic          ex_wr;
    logic [AW-1:0] ex_dst;

    int vecs = 0;
    int bad  = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rawdep_guard u_dut (
        .clk       (clk),
        .rst       (rst),
        .dec_valid (dec_valid),
        .dec_src_a (dec_src_a),
        .dec_rd_a  (dec_rd_a),
        .dec_src_b (dec_src_b),
        .dec_rd_b  (dec_rd_b),
        .dec_dst   (dec_dst),
        .dec_wr    (dec_wr),
        .stall_o   (stall_o),
        .hold_pc   (hold_pc),
        .hold_ifid (hold_ifid),
        .ex_bubble (ex_bubble),
        .ex_valid  (ex_valid),
        .ex_wr     (ex_wr),
        .ex_dst    (ex_dst)
    );

    task automatic check(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // drive decode inputs right after a falling edge
    task automatic slot(input logic v, input int sa, input logic ua,
                        input int sb, input logic ub, input int d, input logic w);
        @(negedge clk);
        dec_valid = v;
        dec_src_a = AW'(sa);
        dec_rd_a  = ua;
        dec_src_b = AW'(sb);
        dec_rd_b  = ub;
        dec_dst   = AW'(d);
        dec_wr    = w;
        #2;
    endtask

    task automatic nop();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 0, 1'b0);
    endtask

    task automatic hold_one();
        @(negedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        dec_valid = 1'b0; dec_src_a = '0; dec_rd_a = 1'b0;
        dec_src_b = '0; dec_rd_b = 1'b0; dec_dst = '0; dec_wr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #2;
        check("R1 stall after reset", int'(stall_o), 0);
        check("R1 ex_valid after reset", int'(ex_valid), 0);
        check("R1 ex_wr after reset", int'(ex_wr), 0);
    endtask

    task automatic t_ex_a();
        do_reset();
        slot(1'b1, 1, 1'b1, 2, 1'b1, 3, 1'b1);
        check("R12 writer no stall", int'(stall_o), 0);
        slot(1'b1, 3, 1'b1, 0, 1'b0, 4, 1'b1);
        check("R2 EX match src A", int'(stall_o), 1);
        check("R10 hold_pc", int'(hold_pc), 1);
        check("R10 hold_ifid", int'(hold_ifid), 1);
        hold_one();
        check("R10 bubble ex_valid", int'(ex_valid), 0);
        check("R10 bubble ex_wr", int'(ex_wr), 0);
        check("R4 MEM match still stalls", int'(stall_o), 1);
        hold_one();
        check("R5 R11 released with writer in WB", int'(stall_o), 0);
        hold_one();
        check("R12 reader enters EX", int'(ex_valid), 1);
        check("R12 reader dst", int'(ex_dst), 4);
    endtask

    task automatic t_ex_b();
        do_reset();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 7, 1'b1);
        slot(1'b1, 1, 1'b1, 7, 1'b1, 2, 1'b1);
        check("R3 EX match src B", int'(stall_o), 1);
    endtask

    task automatic t_mem();
        do_reset();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 4, 1'b1);
        nop();
        slot(1'b1, 4, 1'b1, 0, 1'b0, 5, 1'b1);
        check("R4 MEM match stalls", int'(stall_o), 1);
        hold_one();
        check("R4 R11 one-cycle stall ends", int'(stall_o), 0);
    endtask

    task automatic t_wb();
        do_reset();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 6, 1'b1);
        nop();
        nop();
        slot(1'b1, 6, 1'b1, 6, 1'b1, 8, 1'b1);
        check("R5 WB writer not compared", int'(stall_o), 0);
    endtask

    task automatic t_use();
        do_reset();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 9, 1'b1);
        slot(1'b1, 9, 1'b0, 9, 1'b0, 1, 1'b1);
        check("R6 unused sources", int'(stall_o), 0);
    endtask

    task automatic t_nowr();
        do_reset();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 6, 1'b0);
        slot(1'b1, 6, 1'b1, 0, 1'b0, 2, 1'b1);
        check("R7 write flag clear", int'(stall_o), 0);
        do_reset();
        slot(1'b0, 0, 1'b0, 0, 1'b0, 6, 1'b1);
        slot(1'b1, 6, 1'b1, 6, 1'b1, 2, 1'b1);
        check("R7 empty slot", int'(stall_o), 0);
    endtask

    task automatic t_zero();
        do_reset();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 0, 1'b1);
        slot(1'b1, 0, 1'b1, 0, 1'b1, 3, 1'b1);
        check("R8 register 0", int'(stall_o), 0);
    endtask

    task automatic t_war_waw();
        do_reset();
        slot(1'b1, 1, 1'b1, 2, 1'b1, 5, 1'b1);
        slot(1'b1, 1, 1'b1, 2, 1'b1, 5, 1'b1);
        check("R9 write-after-write", int'(stall_o), 0);
        do_reset();
        slot(1'b1, 8, 1'b1, 0, 1'b0, 0, 1'b0);
        slot(1'b1, 1, 1'b1, 0, 1'b0, 8, 1'b1);
        check("R9 write-after-read", int'(stall_o), 0);
    endtask

    task automatic t_idle();
        do_reset();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 3, 1'b1);
        slot(1'b0, 3, 1'b1, 3, 1'b1, 0, 1'b0);
        check("R13 invalid decode no stall", int'(stall_o), 0);
        check("R13 invalid decode no hold", int'(hold_pc), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        vecs++;
        bad++;
        $display("FAIL watchdog: got 1 expected 0");
        finish_run();
    end

    initial begin
        t_reset();
        t_ex_a();
        t_ex_b();
        t_mem();
        t_wb();
        t_use();
        t_nowr();
        t_zero();
        t_war_waw();
        t_idle();
        finish_run();
    end

endmodule